// File: doc/BRIEF.md
# Frequency-Hopping NCO Phase Generator

This block is the phase engine of a numerically controlled oscillator that feeds a digital down-converter. It keeps a bank of signed 48-bit tuning words and advances a phase by the selected word on every sample clock. The output goes to a sine/cosine lookup that is outside the block. A slot-select input picks which tuning word drives the output, so the frequency can hop within two sample clocks. How many slots can be selected depends on the band configuration.

There are two phase behaviours. In continuous mode, a single accumulator keeps its phase through a hop and simply starts adding the new increment. In coherent mode, every slot owns an accumulator that runs all the time from a common SYSREF alignment pulse, and the select input only steers which one is seen. Returning to an earlier frequency therefore gives the phase that frequency would have reached had it never been left.

Tuning words are loaded one byte at a time through a small register port into a staged copy. They become active only through a commit strobe on a control address, and that strobe must be re-armed before each use. A conjugate option negates the output phase, which turns e^{+jωn} into e^{-jωn}. A registered 16-bit truncation of the phase is provided for the lookup.

Top module: `nco_hop_phase_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every accumulator, every staged and active tuning word and the slot select are cleared to zero, the commit strobe is armed, and `phase_out`, `phase_trunc` and `conj_out` read zero.
- R2: A write to address 8·k+b, with slot k in 0..7 and byte b in 0..5, sets bits [8b+7:8b] of the staged word of slot k, so b=0 is the least significant byte. A write with b equal to 6 or 7 changes nothing.
- R3: Staged words have no effect on the phase until a write of 0x30 to the control address 64 commits all eight staged words to the active bank at once. Any other data value written there, apart from 0x00, does nothing.
- R4: After a commit, further writes of 0x30 are ignored until 0x00 has been written to the control address. Arming happens at reset.
- R5: With `band_cfg` = 0 (one band), all 8 slots can be selected through `sel_in[2:0]`. With any other value (1 = two bands, 2 = four bands, 3 treated alike), only 4 slots can be selected, and `sel_in[2]` is ignored.
- R6: In continuous mode (`coherent` = 0), one accumulator adds the active word of the currently selected slot on every cycle, modulo 2^48, and its phase carries across a hop unchanged.
- R7: In coherent mode, the output follows the accumulator of the selected slot. Each slot accumulator adds its own active word on every cycle whatever the selection, so a slot that is re-selected resumes the phase it would have had without any hop.
- R8: A `sysref` pulse at a clock edge sets the continuous accumulator and all slot accumulators to zero at that edge.
- R9: With `conj_en` = 1, `phase_out` is the two's-complement negation, modulo 2^48, of the selected phase. `conj_out` repeats `conj_en` one cycle later.
- R10: `phase_trunc` always equals the top 16 bits of `phase_out`.
- R11: `phase_out` at clock edge e+1 shows the accumulator value and slot selection held just before edge e+1. A change of `sel_in` sampled at edge e therefore reaches the output at edge e+1, which is within 2 sample clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address: staged word bytes at 0..63, control at 64 |
| reg_wdata | input | 8 | Register write data |
| band_cfg | input | 2 | Band configuration: 0 one band, 1 two bands, 2 four bands |
| sel_in | input | 3 | Tuning slot select |
| coherent | input | 1 | 1 selects coherent mode, 0 selects continuous mode |
| conj_en | input | 1 | Negate the output phase |
| sysref | input | 1 | Alignment pulse that clears all accumulators |
| phase_out | output | 48 | Registered output phase |
| phase_trunc | output | 16 | Top 16 bits of the output phase |
| conj_out | output | 1 | Registered conjugation flag |

## Verification
The phase is compared on every cycle with a behavioural model. The runs cover steady single-slot tones, hops out and back in continuous mode, and the same hop patterns in coherent mode after a SYSREF pulse. In continuous mode the phase must carry across a hop; in coherent mode a re-selected slot must resume its own timeline, and the two cases only differ after a hop back. Select values with bit 2 set are applied under each band setting, which shows whether the slot count is limited. Sequences of byte writes, commits that are not re-armed and unknown control values show whether staged words leak into the active bank early or out of place.

// File: rtl/nco_pkg.sv
// Package: shared constants and the band configuration encoding for the NCO
// phase generator. Assumes a fixed byte stride of 8 addresses per slot.
package nco_pkg;
    typedef enum logic [1:0] {
        BAND_ONE  = 2'd0,
        BAND_TWO  = 2'd1,
        BAND_FOUR = 2'd2,
        BAND_RSVD = 2'd3
    } band_cfg_e;

    localparam logic [7:0] CTRL_COMMIT = 8'h30;
    localparam logic [7:0] CTRL_REARM  = 8'h00;
    localparam int         LANE_STRIDE = 8;
endpackage

// File: rtl/nco_tuning_bank.sv
// Module: staged and active tuning word bank. Byte writes land in the staged
// copy; a commit write to the control address copies all staged words into
// the active copy. The commit must be re-armed by a write of the re-arm code.
// Assumes the word width is a whole number of bytes, at most 8 bytes.
module nco_tuning_bank
    import nco_pkg::*;
#(
    parameter int PH_W   = 48,
    parameter int SLOTS  = 8,
    parameter int SEL_W  = $clog2(SLOTS),
    parameter int ADDR_W = SEL_W + 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    output logic [SLOTS-1:0][PH_W-1:0]  active
);
    localparam int BYTES = PH_W / 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(SLOTS * LANE_STRIDE);

    logic [SLOTS-1:0][PH_W-1:0] staged;
    logic                       armed;
    logic                       ctrl_hit;
    logic                       commit;
    logic                       word_hit;
    logic [SEL_W-1:0]           wr_slot;
    logic [2:0]                 wr_lane;

    // Decode the write address into control access and staged byte access.
    always_comb begin
        ctrl_hit = wr_en && (addr == CTRL_ADDR);
        commit   = ctrl_hit && (wdata == CTRL_COMMIT) && armed;
        wr_slot  = addr[SEL_W+2:3];
        wr_lane  = addr[2:0];
        word_hit = wr_en && !addr[ADDR_W-1] && (int'(wr_lane) < BYTES);
    end

    // Place a written byte into its lane of the staged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (word_hit) begin
            for (int b = 0; b < BYTES; b++) begin
                if (int'(wr_lane) == b) begin
                    staged[wr_slot][b*8 +: 8] <= wdata;
                end
            end
        end
    end

    // Copy the staged bank into the active bank on an armed commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (commit) begin
            active <= staged;
        end
    end

    // Track whether the next commit code will be honoured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (commit) begin
            armed <= 1'b0;
        end else if (ctrl_hit && (wdata == CTRL_REARM)) begin
            armed <= 1'b1;
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active)); // R3
    AST_NO_RECOMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R4
endmodule

// File: rtl/nco_slot_select.sv
// Module: registers the slot select and limits it to the slot count that the
// band configuration allows (all slots for one band, half of them otherwise).
// Assumes SLOTS is a power of two of at least 2.
module nco_slot_select
    import nco_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int SEL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       band_cfg,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_q
);
    localparam logic [SEL_W-1:0] MASK_ALL  = SEL_W'(SLOTS - 1);
    localparam logic [SEL_W-1:0] MASK_HALF = SEL_W'(SLOTS / 2 - 1);

    logic [SEL_W-1:0] sel_mask;

    // Choose the select mask from the band configuration.
    always_comb begin
        sel_mask = (band_cfg_e'(band_cfg) == BAND_ONE) ? MASK_ALL : MASK_HALF;
    end

    // Register the masked select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_in & sel_mask;
        end
    end

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (band_cfg != 2'd0) |=> (int'(sel_q) < SLOTS / 2)); // R5
endmodule

// File: rtl/nco_phase_accum.sv
// Module: phase accumulators. A single continuous accumulator adds the word of
// the selected slot; one coherent accumulator per slot adds its own word every
// cycle. SYSREF clears all of them. The mode only steers the output mux.
module nco_phase_accum #(
    parameter int PH_W  = 48,
    parameter int SLOTS = 8,
    parameter int SEL_W = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sysref,
    input  logic                        coherent,
    input  logic [SEL_W-1:0]            sel_q,
    input  logic [SLOTS-1:0][PH_W-1:0]  active,
    output logic [PH_W-1:0]             phase_sel
);
    logic [PH_W-1:0]            acc_cont;
    logic [SLOTS-1:0][PH_W-1:0] acc_slot;

    // Continuous accumulator: phase carries across hops.
    always_ff @(posedge clk) begin
        if (!rst_n || sysref) begin
            acc_cont <= '0;
        end else begin
            acc_cont <= acc_cont + active[sel_q];
        end
    end

    // One free-running accumulator per slot for coherent hopping.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || sysref) begin
                acc_slot[k] <= '0;
            end else begin
                acc_slot[k] <= acc_slot[k] + active[k];
            end
        end
    end

    // Steer the phase of the active mode to the output stage.
    always_comb begin
        phase_sel = coherent ? acc_slot[sel_q] : acc_cont;
    end

    AST_SYSREF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sysref |=> (acc_cont == '0) && (acc_slot == '0)); // R8
endmodule

// File: rtl/nco_phase_out.sv
// Module: output register stage. Optionally negates the phase for the
// conjugate exponential and registers the full and truncated phase together.
module nco_phase_out #(
    parameter int PH_W  = 48,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conj_en,
    input  logic [PH_W-1:0]  phase_sel,
    output logic [PH_W-1:0]  phase_out,
    output logic [OUT_W-1:0] phase_trunc,
    output logic             conj_out
);
    logic [PH_W-1:0] phase_signed;

    // Negate the phase when the conjugate output is requested.
    always_comb begin
        phase_signed = conj_en ? (~phase_sel + PH_W'(1)) : phase_sel;
    end

    // Register phase, truncated phase and flag with the same latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_out   <= '0;
            phase_trunc <= '0;
            conj_out    <= 1'b0;
        end else begin
            phase_out   <= phase_signed;
            phase_trunc <= phase_signed[PH_W-1 -: OUT_W];
            conj_out    <= conj_en;
        end
    end

    AST_TRUNC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        phase_trunc == phase_out[PH_W-1 -: OUT_W]); // R10
    AST_CONJ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (conj_out == $past(conj_en))); // R9
endmodule

// File: rtl/nco_hop_phase_gen.sv
// Module: top of the frequency-hopping NCO phase generator. Joins the tuning
// bank, the slot select, the accumulators and the output stage. Assumes a
// single sample clock and a synchronous active-low reset.
module nco_hop_phase_gen #(
    parameter int PH_W   = 48,
    parameter int OUT_W  = 16,
    parameter int SLOTS  = 8,
    parameter int SEL_W  = $clog2(SLOTS),
    parameter int ADDR_W = SEL_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [1:0]        band_cfg,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              coherent,
    input  logic              conj_en,
    input  logic              sysref,
    output logic [PH_W-1:0]   phase_out,
    output logic [OUT_W-1:0]  phase_trunc,
    output logic              conj_out
);
    logic [SLOTS-1:0][PH_W-1:0] active;
    logic [SEL_W-1:0]           sel_q;
    logic [PH_W-1:0]            phase_sel;

    nco_tuning_bank #(.PH_W(PH_W), .SLOTS(SLOTS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .active (active)
    );

    nco_slot_select #(.SLOTS(SLOTS), .SEL_W(SEL_W)) select_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .band_cfg (band_cfg),
        .sel_in   (sel_in),
        .sel_q    (sel_q)
    );

    nco_phase_accum #(.PH_W(PH_W), .SLOTS(SLOTS), .SEL_W(SEL_W)) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref    (sysref),
        .coherent  (coherent),
        .sel_q     (sel_q),
        .active    (active),
        .phase_sel (phase_sel)
    );

    nco_phase_out #(.PH_W(PH_W), .OUT_W(OUT_W)) out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .conj_en     (conj_en),
        .phase_sel   (phase_sel),
        .phase_out   (phase_out),
        .phase_trunc (phase_trunc),
        .conj_out    (conj_out)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (phase_out == '0) && !conj_out); // R1
endmodule

// File: tb/nco_hop_phase_gen_tb.sv
module nco_hop_phase_gen_tb_top;
    localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  band_cfg = '0;
    logic [2:0]  sel_in = '0;
    logic        coherent = 1'b0;
    logic        conj_en = 1'b0;
    logic        sysref = 1'b0;
    logic [47:0] phase_out;
    logic [15:0] phase_trunc;
    logic        conj_out;

    nco_hop_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .band_cfg(band_cfg), .sel_in(sel_in),
        .coherent(coherent), .conj_en(conj_en), .sysref(sysref),
        .phase_out(phase_out), .phase_trunc(phase_trunc), .conj_out(conj_out)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // Behavioural reference model state
    longint unsigned m_staged[8];
    longint unsigned m_active[8];
    longint unsigned m_coh[8];
    longint unsigned m_cont = 0;
    int              m_sel = 0;
    bit              m_armed = 1'b1;
    longint unsigned e_phase = 0;
    bit              e_conj = 1'b0;

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_staged[k] = 0; m_active[k] = 0; m_coh[k] = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin
                m_staged[k] = 0; m_active[k] = 0; m_coh[k] = 0;
            end
            m_cont = 0; m_sel = 0; m_armed = 1'b1; e_phase = 0; e_conj = 1'b0;
        end else begin
            longint unsigned ph;
            ph = coherent ? m_coh[m_sel] : m_cont;
            e_phase = conj_en ? ((~ph) + 1) & MASK : ph;
            e_conj = conj_en;
            if (sysref) begin
                m_cont = 0;
                for (int k = 0; k < 8; k++) m_coh[k] = 0;
            end else begin
                m_cont = (m_cont + m_active[m_sel]) & MASK;
                for (int k = 0; k < 8; k++) m_coh[k] = (m_coh[k] + m_active[k]) & MASK;
            end
            m_sel = (band_cfg == 2'd0) ? int'(sel_in) : int'(sel_in) & 3;
            if (reg_wr_en) begin
                if (reg_addr == 7'd64) begin
                    if (reg_wdata == 8'h30 && m_armed) begin
                        for (int k = 0; k < 8; k++) m_active[k] = m_staged[k];
                        m_armed = 1'b0;
                    end else if (reg_wdata == 8'h00) begin
                        m_armed = 1'b1;
                    end
                end else if (reg_addr < 7'd64 && reg_addr[2:0] < 3'd6) begin
                    int s, b;
                    s = int'(reg_addr[5:3]);
                    b = int'(reg_addr[2:0]);
                    m_staged[s] = (m_staged[s] & ~(64'hFF << (8*b))) |
                                  (longint'(reg_wdata) << (8*b));
                end
            end
        end
    end

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare outputs against the model on every falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check({cur_tag, " phase"}, longint'(phase_out), e_phase);
            check("R10 trunc", longint'(phase_trunc), (e_phase >> 32) & 64'hFFFF);
            check("R9 conj flag", longint'(conj_out), longint'(e_conj));
        end
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [6:0] a, logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic load_word(int slot, logic [47:0] w);
        for (int b = 0; b < 6; b++) wr(7'(slot * 8 + b), w[b*8 +: 8]);
    endtask

    initial begin
        idle(4);
        checks++;
        if (phase_out !== '0 || phase_trunc !== '0 || conj_out !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%h expected=0", phase_out);
        end
        rst_n = 1'b1;
        idle(2);
        cur_tag = "R3 staged-only";
        load_word(0, 48'h5A95A95A95A9);
        load_word(1, 48'h0000_1000_0001);
        load_word(2, 48'hF000_0000_0003);
        load_word(5, 48'h1234_5678_9ABC);
        idle(3);
        check("R3 no commit yet", longint'(phase_out), 0);
        cur_tag = "R3 odd code";
        wr(7'd64, 8'h31);
        idle(3);
        check("R3 odd code ignored", longint'(phase_out), 0);
        cur_tag = "R2 lanes";
        wr(7'd6, 8'hEE);
        wr(7'd15, 8'h77);
        wr(7'd64, 8'h30);
        wr(7'd64, 8'h00);
        cur_tag = "R6 continuous";
        idle(6);
        sel_in = 3'd1; cur_tag = "R11 hop";
        idle(5);
        sel_in = 3'd2; cur_tag = "R6 carry";
        idle(5);
        sel_in = 3'd0;
        idle(4);
        cur_tag = "R8 sysref";
        sysref = 1'b1; idle(1); sysref = 1'b0;
        idle(2);
        coherent = 1'b1; cur_tag = "R7 coherent";
        idle(4);
        sel_in = 3'd1; idle(5);
        sel_in = 3'd5; idle(3);
        sel_in = 3'd0; cur_tag = "R7 return";
        idle(4);
        conj_en = 1'b1; cur_tag = "R9 conjugate";
        idle(4);
        coherent = 1'b0; idle(3);
        conj_en = 1'b0;
        cur_tag = "R5 band";
        band_cfg = 2'd1; sel_in = 3'd5; idle(4);
        band_cfg = 2'd2; sel_in = 3'd6; idle(3);
        band_cfg = 2'd0; sel_in = 3'd5; idle(4);
        sel_in = 3'd0;
        cur_tag = "R4 rearm";
        load_word(0, 48'h0000_0000_0100);
        wr(7'd64, 8'h30);
        idle(3);
        load_word(0, 48'h8000_0000_0000);
        wr(7'd64, 8'h30);
        idle(4);
        wr(7'd64, 8'h00);
        wr(7'd64, 8'h30);
        idle(4);
        cur_tag = "R8 sysref cont";
        sysref = 1'b1; idle(1); sysref = 1'b0;
        idle(4);
        rst_n = 1'b0; idle(2);
        checks++;
        if (phase_out !== '0 || conj_out !== 1'b0) begin
            failures++;
            $display("FAIL R1 mid reset actual=%h expected=0", phase_out);
        end
        rst_n = 1'b1; cur_tag = "R1 after reset";
        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule